// File: doc/BRIEF.md
# Host Port Slave Controller

This block lets an external host reach on-chip memory through a 16-bit asynchronous port. The host sees three 32-bit registers (control, address and data) and moves each 32-bit word as two half-word transfers. The host's chip select and its two data strobes are combined into one internal strobe. The select lines can also be captured on an address strobe. Every host input passes through a two-flop synchroniser, and strobe edges are found in the local clock domain.

Reads and writes of the data register become requests on a level request / pulse acknowledge memory interface. An active-low ready output tells the host when it must hold its strobe. A data read fetches its word when the first half-word begins. A data write, or an autoincrement read, goes busy after the second half-word. After an autoincrement read the next word is prefetched. The pad drivers are external. The block supplies the read half-word and an output-enable.

State machine: `ST_IDLE` (no memory traffic), `ST_FETCH` (read for the current access), `ST_STORE` (write of the assembled word), `ST_PREFETCH` (read of the next word after an autoincrement read). The transitions are:
- IDLE→FETCH: first-half data read starts with no prefetched word.
- IDLE→STORE: second-half data write completes.
- IDLE→PREFETCH: second-half autoincrement read completes.
- FETCH/STORE/PREFETCH→IDLE: memory acknowledge.

Top module: `hostport_slave`

## Requirements
- R1: After reset the control, address and data registers are zero, no memory request is raised, the output-enable is low and ready is low.
- R2: The internal strobe is active only when chip select is low and the two data strobes differ. Any other combination moves no data, and the written half-word is taken when the strobe goes inactive.
- R3: Half-word identifier 0 addresses bits 15:0 of the selected register and 1 addresses bits 31:16, for both reads and writes.
- R4: Register select 00 is control, 01 is data with autoincrement, 10 is address and 11 is data without autoincrement.
- R5: While chip select is high, ready is low whatever the internal state. If a transfer is still pending when chip select falls, ready goes high at once.
- R6: The start of a first-half data read with no prefetched word raises one memory read at the current address. Ready stays high until the word is loaded into the data register, and the second half raises no request.
- R7: The end of a second-half data write raises one memory write of the assembled word at the current address. Ready stays high until the acknowledge.
- R8: Control and address register accesses never make ready high.
- R9: After the memory write of an autoincrement data write, the address register has grown by 4. A write with select 11 leaves the address unchanged.
- R10: The end of a second-half autoincrement read adds 4 to the address and prefetches that word. The next first-half data read raises no request and returns the prefetched word.
- R11: The output-enable is high only while the strobe is active and the access is a read.
- R12: With address strobe latching enabled, the select lines are taken at the falling edge of the address strobe. Later changes before the data strobe are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_ds1_n | input | 1 | Host data strobe one |
| h_ds2_n | input | 1 | Host data strobe two |
| h_as_n | input | 1 | Host address strobe, active low |
| h_sel | input | 2 | Register select |
| h_rd | input | 1 | 1 = read, 0 = write |
| h_hi | input | 1 | Half-word identifier, 0 = low half |
| h_din | input | HW | Host write data |
| h_dout | output | HW | Host read data |
| h_doe | output | 1 | Output-enable for the host data pads |
| h_rdy_n | output | 1 | Ready, low = ready, high = busy |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 2*HW | Memory byte address |
| mem_wdata | output | 2*HW | Memory write data |
| mem_rdata | input | 2*HW | Memory read data |
| mem_ack | input | 1 | Memory acknowledge, one-cycle pulse |
| ctl_reg | output | 2*HW | Control register contents |

## Verification
Chip-select gating of ready and a pending memory store can hold at the same time. The bench provokes this by lifting chip select while a data write is still waiting for its acknowledge. Ready must read low while the request is still high, and it must go high again the moment chip select returns. A second overlap comes when a prefetch completes just as the next first-half read begins. The bench judges it by the request count, which must not grow, and by the returned half-word, which must be the next memory word.

// File: rtl/hps_pkg.sv
package hps_pkg;

    typedef enum logic [1:0] {
        SEL_CTL     = 2'b00,
        SEL_DAT_INC = 2'b01,
        SEL_ADR     = 2'b10,
        SEL_DAT     = 2'b11
    } hsel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_PREFETCH
    } hps_state_e;

    typedef struct packed {
        hsel_e sel;
        logic  rd;
        logic  hi;
    } hacc_t;

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hps_front.sv
module hps_front import hps_pkg::*; #(
    parameter bit LATCH_ON_AS = 1'b0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cs_n,
    input  logic  ds1_n,
    input  logic  ds2_n,
    input  logic  as_n,
    input  hacc_t sel_in,
    output hacc_t acc,
    output logic  start,
    output logic  rise,
    output logic  active
);
    logic  stb_n;
    logic  stb_q;
    logic  as_q;
    logic  fall;
    logic  as_fall;
    hacc_t as_hold;
    hacc_t src;

    // composite strobe: active low when selected and exactly one data strobe low
    assign stb_n   = ~(ds1_n ^ ds2_n) | cs_n;
    assign fall    = stb_q & ~stb_n;
    assign rise    = ~stb_q & stb_n;
    assign as_fall = as_q & ~as_n;
    assign active  = ~stb_q;

    // selects captured at the same edge as the address strobe are taken directly
    assign src = (LATCH_ON_AS && !as_fall) ? as_hold : sel_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q   <= 1'b1;
            as_q    <= 1'b1;
            start   <= 1'b0;
            as_hold <= '0;
            acc     <= '0;
        end else begin
            stb_q <= stb_n;
            as_q  <= as_n;
            start <= fall;
            if (as_fall) as_hold <= sel_in;
            if (fall)    acc     <= src;
        end
    end
endmodule

// File: rtl/hps_ctrl.sv
module hps_ctrl import hps_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       rise,
    input  hacc_t      acc,
    input  logic       pf_valid,
    input  logic       mem_ack,
    output hps_state_e state,
    output logic       busy,
    output logic       mem_req,
    output logic       mem_we,
    output logic       ld_rdata,
    output logic       inc_addr,
    output logic       pf_set,
    output logic       pf_take
);
    hps_state_e nxt;
    logic       inc_q;
    logic       dat_sel;
    logic       rd_first;
    logic       wr_second;
    logic       inc_rd_second;

    assign dat_sel       = (acc.sel == SEL_DAT) || (acc.sel == SEL_DAT_INC);
    assign rd_first      = start && dat_sel && acc.rd && !acc.hi;
    assign wr_second     = rise && dat_sel && !acc.rd && acc.hi;
    assign inc_rd_second = rise && (acc.sel == SEL_DAT_INC) && acc.rd && acc.hi;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rd_first && !pf_valid) nxt = ST_FETCH;
                else if (wr_second)        nxt = ST_STORE;
                else if (inc_rd_second)    nxt = ST_PREFETCH;
            end
            ST_FETCH, ST_STORE, ST_PREFETCH: begin
                if (mem_ack) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            inc_q <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && nxt == ST_STORE)
                inc_q <= (acc.sel == SEL_DAT_INC);
        end
    end

    always_comb begin
        busy     = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        ld_rdata = 1'b0;
        inc_addr = 1'b0;
        pf_set   = 1'b0;
        pf_take  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                pf_take  = rd_first && pf_valid;
                inc_addr = (nxt == ST_PREFETCH);
            end
            ST_FETCH: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                ld_rdata = mem_ack;
            end
            ST_STORE: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                inc_addr = mem_ack && inc_q;
            end
            ST_PREFETCH: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                ld_rdata = mem_ack;
                pf_set   = mem_ack;
            end
            default: ;
        endcase
    end

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));

    assert_fetch_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rd_first && !pf_valid) |=> (mem_req && !mem_we));
endmodule

// File: rtl/hostport_slave.sv
module hostport_slave import hps_pkg::*; #(
    parameter int HW          = 16,
    parameter bit LATCH_ON_AS = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_cs_n,
    input  logic          h_ds1_n,
    input  logic          h_ds2_n,
    input  logic          h_as_n,
    input  logic [1:0]    h_sel,
    input  logic          h_rd,
    input  logic          h_hi,
    input  logic [HW-1:0] h_din,
    output logic [HW-1:0] h_dout,
    output logic          h_doe,
    output logic          h_rdy_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [2*HW-1:0] mem_addr,
    output logic [2*HW-1:0] mem_wdata,
    input  logic [2*HW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic [2*HW-1:0] ctl_reg
);
    localparam int RW   = 2 * HW;
    localparam int STEP = RW / 8;

    logic [3:0]    strb_raw;
    logic [3:0]    strb_s;
    logic [3:0]    sel_raw;
    logic [3:0]    sel_bits;
    hacc_t         sel_s;
    logic [HW-1:0] din_s;
    hacc_t         acc;
    logic          start;
    logic          rise;
    logic          active;
    hps_state_e    state;
    logic          busy;
    logic          ld_rdata;
    logic          inc_addr;
    logic          pf_set;
    logic          pf_take;
    logic [RW-1:0] ctl_q;
    logic [RW-1:0] adr_q;
    logic [RW-1:0] dat_q;
    logic          pf_q;
    logic [RW-1:0] rd_word;

    assign strb_raw = {h_cs_n, h_ds1_n, h_ds2_n, h_as_n};
    assign sel_raw  = {h_sel, h_rd, h_hi};
    assign sel_s    = hacc_t'(sel_bits);

    hps_sync #(.W(4), .RST_VAL(4'hF)) u_sync_strb (
        .clk(clk), .rst_n(rst_n), .d(strb_raw), .q(strb_s));

    hps_sync #(.W(4), .RST_VAL(4'h0)) u_sync_sel (
        .clk(clk), .rst_n(rst_n), .d(sel_raw), .q(sel_bits));

    hps_sync #(.W(HW), .RST_VAL('0)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .d(h_din), .q(din_s));

    hps_front #(.LATCH_ON_AS(LATCH_ON_AS)) u_front (
        .clk(clk), .rst_n(rst_n),
        .cs_n(strb_s[3]), .ds1_n(strb_s[2]), .ds2_n(strb_s[1]), .as_n(strb_s[0]),
        .sel_in(sel_s), .acc(acc), .start(start), .rise(rise), .active(active));

    hps_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .rise(rise), .acc(acc),
        .pf_valid(pf_q), .mem_ack(mem_ack), .state(state), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .ld_rdata(ld_rdata),
        .inc_addr(inc_addr), .pf_set(pf_set), .pf_take(pf_take));

    function automatic logic [RW-1:0] put_half(input logic [RW-1:0] w,
                                               input logic hi,
                                               input logic [HW-1:0] v);
        put_half = hi ? {v, w[HW-1:0]} : {w[RW-1:HW], v};
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            adr_q <= '0;
            dat_q <= '0;
            pf_q  <= 1'b0;
        end else begin
            if (inc_addr) adr_q <= adr_q + RW'(STEP);
            if (ld_rdata) dat_q <= mem_rdata;
            if (pf_set)       pf_q <= 1'b1;
            else if (pf_take) pf_q <= 1'b0;
            if (rise && !acc.rd) begin
                unique case (acc.sel)
                    SEL_CTL: ctl_q <= put_half(ctl_q, acc.hi, din_s);
                    SEL_ADR: begin
                        adr_q <= put_half(adr_q, acc.hi, din_s);
                        pf_q  <= 1'b0;
                    end
                    SEL_DAT, SEL_DAT_INC: begin
                        dat_q <= put_half(dat_q, acc.hi, din_s);
                        pf_q  <= 1'b0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (acc.sel)
            SEL_CTL:              rd_word = ctl_q;
            SEL_ADR:              rd_word = adr_q;
            SEL_DAT, SEL_DAT_INC: rd_word = dat_q;
            default:              rd_word = dat_q;
        endcase
    end

    assign h_dout    = acc.hi ? rd_word[RW-1:HW] : rd_word[HW-1:0];
    assign h_doe     = active & acc.rd;
    assign h_rdy_n   = ~h_cs_n & busy;
    assign mem_addr  = adr_q;
    assign mem_wdata = dat_q;
    assign ctl_reg   = ctl_q;

    assert_ctl_adr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && (acc.sel == SEL_CTL || acc.sel == SEL_ADR) && !busy) |=> !busy);

    assert_autoinc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_addr && !rise) |=> (adr_q == $past(adr_q) + RW'(STEP)));

    assert_prefetch_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREFETCH && mem_ack) |=> (pf_q && state == ST_IDLE));
endmodule

// File: tb/sim_hostport_slave.sv
module sim_hostport_slave;
    localparam int CLK_NS = 10;
    localparam int LAT    = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_cs_n = 1'b1, h_ds1_n = 1'b1, h_ds2_n = 1'b1, h_as_n = 1'b1;
    logic [1:0]  h_sel = 2'b00;
    logic        h_rd = 1'b0, h_hi = 1'b0;
    logic [15:0] h_din = '0;
    logic [15:0] h_dout, u1_dout;
    logic        h_doe, h_rdy_n, u1_doe, u1_rdy_n;
    logic        mem_req, mem_we, u1_req, u1_we;
    logic        mem_ack = 1'b0, u1_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, ctl_reg;
    logic [31:0] u1_addr, u1_wdata, u1_ctl;

    logic [31:0] mem [0:63];
    int          lat_cnt = 0;
    int          req_count = 0;
    logic        req_d = 1'b0;
    bit          busy_seen = 1'b0;
    int          nchk = 0;
    int          nfail = 0;

    always #(CLK_NS/2) clk = ~clk;

    hostport_slave #(.HW(16), .LATCH_ON_AS(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .h_cs_n(h_cs_n), .h_ds1_n(h_ds1_n), .h_ds2_n(h_ds2_n),
        .h_as_n(h_as_n), .h_sel(h_sel), .h_rd(h_rd), .h_hi(h_hi), .h_din(h_din),
        .h_dout(h_dout), .h_doe(h_doe), .h_rdy_n(h_rdy_n), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .ctl_reg(ctl_reg));

    hostport_slave #(.HW(16), .LATCH_ON_AS(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .h_cs_n(h_cs_n), .h_ds1_n(h_ds1_n), .h_ds2_n(h_ds2_n),
        .h_as_n(h_as_n), .h_sel(h_sel), .h_rd(h_rd), .h_hi(h_hi), .h_din(h_din),
        .h_dout(u1_dout), .h_doe(u1_doe), .h_rdy_n(u1_rdy_n), .mem_req(u1_req),
        .mem_we(u1_we), .mem_addr(u1_addr), .mem_wdata(u1_wdata),
        .mem_rdata(32'h0), .mem_ack(u1_ack), .ctl_reg(u1_ctl));

    function automatic logic [31:0] init_word(int i);
        return 32'h5A00_0000 | (32'(i) << 8) | 32'(i);
    endfunction

    // memory model: acknowledge after LAT cycles of request
    always @(posedge clk) begin
        req_d <= mem_req;
        if (mem_req && !req_d) req_count <= req_count + 1;
        if (mem_req && !mem_ack) begin
            if (lat_cnt == LAT) begin
                mem_ack <= 1'b1;
                lat_cnt <= 0;
                if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[7:2]];
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
        u1_ack <= u1_req && !u1_ack;
        if (h_rdy_n) busy_seen <= 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_ready();
        int n = 0;
        while (h_rdy_n !== 1'b0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (n >= 400) chk("ready timeout", 32'(h_rdy_n), 32'h0);
    endtask

    task automatic access(input logic [1:0] sel, input logic rd, input logic hi,
                          input logic [15:0] wd, output logic [15:0] rv,
                          output logic doe_low, output logic doe_high);
        h_cs_n = 1'b0; h_sel = sel; h_rd = rd; h_hi = hi; h_din = wd;
        repeat (3) @(negedge clk);
        wait_ready();
        h_ds1_n = 1'b0;
        repeat (6) @(negedge clk);
        wait_ready();
        repeat (3) @(negedge clk);
        rv = h_dout; doe_low = h_doe;
        h_ds1_n = 1'b1;
        repeat (6) @(negedge clk);
        doe_high = h_doe;
    endtask

    task automatic hwrite(input logic [1:0] sel, input logic hi, input logic [15:0] wd);
        logic [15:0] rv; logic a, b;
        access(sel, 1'b0, hi, wd, rv, a, b);
    endtask

    task automatic hread(input logic [1:0] sel, input logic hi, output logic [15:0] rv);
        logic a, b;
        access(sel, 1'b1, hi, 16'h0, rv, a, b);
    endtask

    task automatic t_reset();
        chk("R1 ready low", 32'(h_rdy_n), 32'h0);
        chk("R1 no request", 32'(mem_req), 32'h0);
        chk("R1 doe low", 32'(h_doe), 32'h0);
        chk("R1 control zero", ctl_reg, 32'h0);
    endtask

    task automatic t_ctl();
        logic [15:0] rv; logic dl, dh;
        busy_seen = 1'b0;
        hwrite(2'b00, 1'b0, 16'h5678);
        hwrite(2'b00, 1'b1, 16'h1234);
        chk("R3 R4 control assembled", ctl_reg, 32'h1234_5678);
        access(2'b00, 1'b1, 1'b0, 16'h0, rv, dl, dh);
        chk("R3 control low half", 32'(rv), 32'h5678);
        chk("R11 doe during read", 32'(dl), 32'h1);
        chk("R11 doe after strobe", 32'(dh), 32'h0);
        hread(2'b00, 1'b1, rv);
        chk("R3 control high half", 32'(rv), 32'h1234);
        chk("R8 control never busy", 32'(busy_seen), 32'h0);
    endtask

    task automatic t_addr(input logic [15:0] a);
        logic [15:0] rv;
        busy_seen = 1'b0;
        hwrite(2'b10, 1'b0, a);
        hwrite(2'b10, 1'b1, 16'h0);
        hread(2'b10, 1'b0, rv);
        chk("R4 address readback", 32'(rv), 32'(a));
        chk("R8 address never busy", 32'(busy_seen), 32'h0);
    endtask

    task automatic t_strobe_decode();
        h_cs_n = 1'b0; h_sel = 2'b00; h_rd = 1'b0; h_hi = 1'b0; h_din = 16'hFFFF;
        repeat (3) @(negedge clk);
        h_ds1_n = 1'b0; h_ds2_n = 1'b0;
        repeat (6) @(negedge clk);
        h_ds1_n = 1'b1; h_ds2_n = 1'b1;
        repeat (6) @(negedge clk);
        h_cs_n = 1'b1;
        repeat (3) @(negedge clk);
        h_ds1_n = 1'b0;
        repeat (6) @(negedge clk);
        h_ds1_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R2 invalid strobes ignored", ctl_reg, 32'h1234_5678);
    endtask

    task automatic t_data_write();
        logic [15:0] rv; logic dl, dh;
        t_addr(16'h0010);
        access(2'b11, 1'b0, 1'b0, 16'hF00D, rv, dl, dh);
        chk("R11 doe low on write", 32'(dl), 32'h0);
        busy_seen = 1'b0;
        hwrite(2'b11, 1'b1, 16'hCAFE);
        wait_ready();
        chk("R7 busy after second half", 32'(busy_seen), 32'h1);
        chk("R7 memory written", mem[4], 32'hCAFE_F00D);
        hread(2'b10, 1'b0, rv);
        chk("R9 no increment on select 11", 32'(rv), 32'h0010);
    endtask

    task automatic t_data_read();
        logic [15:0] rv; int rc0;
        t_addr(16'h0014);
        rc0 = req_count;
        busy_seen = 1'b0;
        hread(2'b11, 1'b0, rv);
        chk("R6 fetched low half", 32'(rv), {16'h0, init_word(5)[15:0]});
        chk("R6 busy during fetch", 32'(busy_seen), 32'h1);
        chk("R6 one request", 32'(req_count), 32'(rc0 + 1));
        hread(2'b11, 1'b1, rv);
        chk("R6 fetched high half", 32'(rv), {16'h0, init_word(5)[31:16]});
        chk("R6 no request on second half", 32'(req_count), 32'(rc0 + 1));
    endtask

    task automatic t_autoinc_write();
        logic [15:0] rv;
        t_addr(16'h0020);
        hwrite(2'b01, 1'b0, 16'h2222);
        hwrite(2'b01, 1'b1, 16'h1111);
        hwrite(2'b01, 1'b0, 16'h4444);
        hwrite(2'b01, 1'b1, 16'h3333);
        wait_ready();
        chk("R9 first word", mem[8], 32'h1111_2222);
        chk("R9 second word", mem[9], 32'h3333_4444);
        hread(2'b10, 1'b0, rv);
        chk("R9 address stepped twice", 32'(rv), 32'h0028);
    endtask

    task automatic t_autoinc_read();
        logic [15:0] rv; int rc0;
        t_addr(16'h0030);
        rc0 = req_count;
        hread(2'b01, 1'b0, rv);
        chk("R10 word one low", 32'(rv), {16'h0, init_word(12)[15:0]});
        hread(2'b01, 1'b1, rv);
        chk("R10 word one high", 32'(rv), {16'h0, init_word(12)[31:16]});
        wait_ready();
        chk("R10 fetch plus prefetch", 32'(req_count), 32'(rc0 + 2));
        hread(2'b10, 1'b0, rv);
        chk("R10 address stepped", 32'(rv), 32'h0034);
        hread(2'b01, 1'b0, rv);
        chk("R10 prefetched low", 32'(rv), {16'h0, init_word(13)[15:0]});
        chk("R10 no request on prefetched", 32'(req_count), 32'(rc0 + 2));
        hread(2'b01, 1'b1, rv);
        chk("R10 prefetched high", 32'(rv), {16'h0, init_word(13)[31:16]});
        wait_ready();
    endtask

    task automatic t_cs_gate();
        hwrite(2'b11, 1'b0, 16'hBEEF);
        hwrite(2'b11, 1'b1, 16'h0BAD);
        chk("R7 busy with select low", 32'(h_rdy_n), 32'h1);
        h_cs_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 ready low while deselected", 32'(h_rdy_n), 32'h0);
        chk("R5 transfer still pending", 32'(mem_req), 32'h1);
        h_cs_n = 1'b0;
        @(negedge clk);
        chk("R5 busy on reselect", 32'(h_rdy_n), 32'h1);
        wait_ready();
        chk("R7 word stored at stepped address", mem[14], 32'h0BAD_BEEF);
    endtask

    task automatic t_as_latch();
        h_cs_n = 1'b0; h_sel = 2'b00; h_rd = 1'b0; h_hi = 1'b0; h_din = 16'hBEEF;
        repeat (3) @(negedge clk);
        wait_ready();
        h_as_n = 1'b0;
        repeat (4) @(negedge clk);
        h_sel = 2'b10;
        repeat (4) @(negedge clk);
        h_ds1_n = 1'b0;
        repeat (6) @(negedge clk);
        h_ds1_n = 1'b1;
        repeat (6) @(negedge clk);
        h_as_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R12 latched select hit control", {16'h0, u1_ctl[15:0]}, 32'h0000_BEEF);
        chk("R12 unlatched instance hit address", ctl_reg, 32'h1234_5678);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = init_word(i);
    end

    initial begin
        #(CLK_NS * 150000);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=done", nchk);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_ctl();
        t_strobe_decode();
        t_data_write();
        t_data_read();
        t_autoinc_write();
        t_autoinc_read();
        t_cs_gate();
        t_as_latch();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule